// File: doc/BRIEF.md
# Segment Descriptor Loader and Privilege Checker

This block turns a 64-bit segment descriptor and a 16-bit selector into the hidden state of a segment register. That state is a 32-bit base, a 32-bit limit expanded for granularity, and a compact attribute word. Code and data segments fill the attribute word in different ways. On the same load strobe the block can also apply one of two privilege checks against the current privilege level. The stack-segment check is used when a stack selector is loaded. The return check is used when a code selector is reloaded on a far return. The block reports a general-protection, stack or segment-not-present fault, along with an error code.

All outputs are registered. They reflect a load one clock after the strobe. The fault and error outputs are single-cycle pulses. The loaded segment state changes only when the load is clean: the selector is not null, the descriptor is a present code or data descriptor, and the selected check raised no fault. In every other case the previous state is kept. A zero flag records whether the last enabled load used a null selector.

Top module: `seg_desc_loader`

## Requirements
- R1: A selector whose bits [15:2] (index and table bit) are all zero is null, whatever the requested privilege in bits [1:0]. A load with a null selector leaves base_o, limit_o and attr_o unchanged.
- R2: After a clean load, base_o equals descriptor bits [63:56] placed at base bits [31:24], with descriptor bits [39:16] at base bits [23:0].
- R3: The raw limit is descriptor bits [51:48] above bits [15:0]. When bit 55 (granularity) is 0, limit_o is the raw limit zero-extended. When bit 55 is 1, limit_o is the raw limit shifted left by 12, with bits [11:0] set to one.
- R4: attr_o[1:0] is descriptor bits [46:45] (privilege), attr_o[2] is bit 54 (default size), attr_o[9] is bit 52 and attr_o[10] is bit 40. For a code segment (bit 43 = 1), attr_o[3]=1, readable attr_o[4]=bit 41, attr_o[5]=0, attr_o[6]=0, long attr_o[7]=bit 53 and conforming attr_o[8]=bit 42.
- R5: For a data segment (bit 43 = 0), attr_o[3]=0, attr_o[4]=1, writable attr_o[5]=bit 41, expand-down attr_o[6]=bit 42, attr_o[7]=0 and attr_o[8]=0.
- R6: When a non-null selector comes with a system descriptor (bit 44 = 0) or a not-present descriptor (bit 47 = 0), desc_err_o pulses and the segment state is not loaded.
- R7: Stack check (chk_mode_i = 1) with a null selector raises a general-protection fault, except when long64_i = 1 and cpl_i is not 3. In that case no fault is raised.
- R8: Stack check with a non-null selector raises a general-protection fault in any of these cases: the descriptor is not a writable data segment, the descriptor privilege differs from cpl_i, or the selector's requested privilege differs from cpl_i.
- R9: Stack check with a non-null selector that passes R8 but has bit 47 clear raises a stack fault.
- R10: Return check (chk_mode_i = 2) raises a general-protection fault in any of these cases: the selector is null, the requested privilege is numerically below cpl_i, the descriptor is not a code segment, a non-conforming segment's privilege differs from the requested privilege, or a conforming segment's privilege exceeds the requested privilege.
- R11: Return check that passes R10 but has bit 47 clear raises a segment-not-present fault. chk_mode_i values 0 and 3 apply no privilege check.
- R12: When a load has zf_en_i = 1, zf_o becomes 1 for a null selector and 0 otherwise. When a load has zf_en_i = 0, zf_o holds its value.
- R13: Outputs respond one clock after load_i. The fault, desc_err_o and err_code_o outputs are zero except in that cycle, and at most one fault is asserted at a time. When a fault is asserted, err_code_o equals the selector, and the segment state is not loaded. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| load_i | input | 1 | Load strobe |
| desc_i | input | 64 | Segment descriptor |
| sel_i | input | 16 | Segment selector |
| cpl_i | input | 2 | Current privilege level |
| long64_i | input | 1 | Processor is in 64-bit mode |
| chk_mode_i | input | 2 | 0 none, 1 stack check, 2 return check, 3 none |
| zf_en_i | input | 1 | Enables the zero-flag update |
| base_o | output | 32 | Loaded segment base |
| limit_o | output | 32 | Loaded, expanded segment limit |
| attr_o | output | 11 | Loaded attribute word |
| zf_o | output | 1 | Null-selector flag |
| gp_fault_o | output | 1 | General-protection fault pulse |
| ss_fault_o | output | 1 | Stack fault pulse |
| np_fault_o | output | 1 | Segment-not-present fault pulse |
| desc_err_o | output | 1 | System or not-present descriptor pulse |
| err_code_o | output | 16 | Fault error code (the selector) |

## Verification
Descriptors are built with chosen bases, limits and type fields. Clean data and code loads with granularity off and on separate the limit expansion from the base assembly, and the two attribute encodings from each other. Null selectors with different privilege bits, system descriptors and not-present descriptors show that the state is held while the zero flag and the error pulse still respond. Each stack and return fault condition is stimulated on its own, with the other conditions satisfied. This identifies which rule raised the fault and shows the priority between a protection fault and a not-present fault.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int DESC_W = 64;
  localparam int SEL_W  = 16;
  localparam int BASE_W = 32;
  localparam int LIM_W  = 32;
  localparam int RAWL_W = 20;
  localparam int ATTR_W = 11;

  typedef enum logic [1:0] {
    CHK_NONE  = 2'd0,
    CHK_STACK = 2'd1,
    CHK_RET   = 2'd2,
    CHK_RSVD  = 2'd3
  } chk_mode_e;

  // Type and privilege fields needed by the checks.
  typedef struct packed {
    logic       sys_n;    // 1 = code or data descriptor
    logic       present;
    logic       is_code;
    logic       rw;       // code: readable, data: writable
    logic       ce;       // code: conforming, data: expand-down
    logic [1:0] dpl;
  } desc_flags_t;

  function automatic logic sel_is_null(input logic [SEL_W-1:0] sel);
    return (sel[SEL_W-1:2] == '0);
  endfunction

  function automatic logic [BASE_W-1:0] join_base(input logic [DESC_W-1:0] d);
    return {d[63:56], d[39:16]};
  endfunction

  function automatic logic [RAWL_W-1:0] raw_limit(input logic [DESC_W-1:0] d);
    return {d[51:48], d[15:0]};
  endfunction

  function automatic logic [ATTR_W-1:0] build_attr(input logic [DESC_W-1:0] d);
    logic [ATTR_W-1:0] a;
    a       = '0;
    a[1:0]  = d[46:45];
    a[2]    = d[54];
    a[9]    = d[52];
    a[10]   = d[40];
    if (d[43]) begin
      a[3] = 1'b1;
      a[4] = d[41];
      a[7] = d[53];
      a[8] = d[42];
    end else begin
      a[4] = 1'b1;
      a[5] = d[41];
      a[6] = d[42];
    end
    return a;
  endfunction

  function automatic desc_flags_t get_flags(input logic [DESC_W-1:0] d);
    desc_flags_t f;
    f.sys_n   = d[44];
    f.present = d[47];
    f.is_code = d[43];
    f.rw      = d[41];
    f.ce      = d[42];
    f.dpl     = d[46:45];
    return f;
  endfunction
endpackage

// File: rtl/seg_field_unpack.sv
module seg_field_unpack
  import seg_pkg::*;
#(
  parameter int GRAN_SHIFT = 12
) (
  input  logic [DESC_W-1:0] desc_i,
  output logic [BASE_W-1:0] base_o,
  output logic [LIM_W-1:0]  limit_o,
  output logic [ATTR_W-1:0] attr_o,
  output desc_flags_t       flags_o
);
  localparam logic [LIM_W-1:0] FILL = (LIM_W'(1) << GRAN_SHIFT) - LIM_W'(1);

  logic [LIM_W-1:0] raw_ext;
  logic             gran;

  assign raw_ext = LIM_W'(raw_limit(desc_i));
  assign gran    = desc_i[55];

  assign base_o  = join_base(desc_i);
  assign limit_o = gran ? ((raw_ext << GRAN_SHIFT) | FILL) : raw_ext;
  assign attr_o  = build_attr(desc_i);
  assign flags_o = get_flags(desc_i);
endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check
  import seg_pkg::*;
(
  input  chk_mode_e   mode_i,
  input  logic        null_i,
  input  logic [1:0]  rpl_i,
  input  logic [1:0]  cpl_i,
  input  logic        long64_i,
  input  desc_flags_t flags_i,
  output logic        gp_o,
  output logic        ss_o,
  output logic        np_o
);
  logic stack_bad;
  logic ret_bad;

  assign stack_bad = !flags_i.sys_n || flags_i.is_code || !flags_i.rw ||
                     (flags_i.dpl != cpl_i) || (rpl_i != cpl_i);
  assign ret_bad   = null_i || (rpl_i < cpl_i) || !flags_i.sys_n || !flags_i.is_code ||
                     (!flags_i.ce && (flags_i.dpl != rpl_i)) ||
                     (flags_i.ce && (flags_i.dpl > rpl_i));

  always_comb begin
    gp_o = 1'b0;
    ss_o = 1'b0;
    np_o = 1'b0;
    case (mode_i)
      CHK_STACK: begin
        if (null_i)              gp_o = !(long64_i && (cpl_i != 2'd3));
        else if (stack_bad)      gp_o = 1'b1;
        else if (!flags_i.present) ss_o = 1'b1;
      end
      CHK_RET: begin
        if (ret_bad)             gp_o = 1'b1;
        else if (!flags_i.present) np_o = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/seg_state_reg.sv
module seg_state_reg
  import seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              commit_i,
  input  logic              zf_en_i,
  input  logic              null_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic              gp_i,
  input  logic              ss_i,
  input  logic              np_i,
  input  logic              derr_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic [BASE_W-1:0] base_o,
  output logic [LIM_W-1:0]  limit_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic              zf_o,
  output logic              gp_o,
  output logic              ss_o,
  output logic              np_o,
  output logic              derr_o,
  output logic [SEL_W-1:0]  err_o
);
  logic any_fault;
  assign any_fault = gp_i | ss_i | np_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_o  <= '0;
      limit_o <= '0;
      attr_o  <= '0;
    end else if (commit_i) begin
      base_o  <= base_i;
      limit_o <= limit_i;
      attr_o  <= attr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 zf_o <= 1'b0;
    else if (load_i && zf_en_i) zf_o <= null_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gp_o   <= 1'b0;
      ss_o   <= 1'b0;
      np_o   <= 1'b0;
      derr_o <= 1'b0;
      err_o  <= '0;
    end else begin
      gp_o   <= load_i & gp_i;
      ss_o   <= load_i & ss_i;
      np_o   <= load_i & np_i;
      derr_o <= load_i & derr_i;
      err_o  <= (load_i && any_fault) ? sel_i : '0;
    end
  end
endmodule

// File: rtl/seg_desc_loader.sv
module seg_desc_loader
  import seg_pkg::*;
#(
  parameter int GRAN_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [63:0]       desc_i,
  input  logic [15:0]       sel_i,
  input  logic [1:0]        cpl_i,
  input  logic              long64_i,
  input  logic [1:0]        chk_mode_i,
  input  logic              zf_en_i,
  output logic [31:0]       base_o,
  output logic [31:0]       limit_o,
  output logic [10:0]       attr_o,
  output logic              zf_o,
  output logic              gp_fault_o,
  output logic              ss_fault_o,
  output logic              np_fault_o,
  output logic              desc_err_o,
  output logic [15:0]       err_code_o
);
  logic [BASE_W-1:0] new_base_w;
  logic [LIM_W-1:0]  new_limit_w;
  logic [ATTR_W-1:0] new_attr_w;
  desc_flags_t       flags_w;
  logic              null_sel_w;
  logic              gp_w, ss_w, np_w;
  logic              derr_w;
  logic              commit_w;

  assign null_sel_w = sel_is_null(sel_i);
  assign derr_w     = !null_sel_w && (!flags_w.sys_n || !flags_w.present);
  assign commit_w   = load_i && !null_sel_w && !derr_w && !(gp_w | ss_w | np_w);

  seg_field_unpack #(.GRAN_SHIFT(GRAN_SHIFT)) u_unpack (
    .desc_i  (desc_i),
    .base_o  (new_base_w),
    .limit_o (new_limit_w),
    .attr_o  (new_attr_w),
    .flags_o (flags_w)
  );

  seg_priv_check u_check (
    .mode_i   (chk_mode_e'(chk_mode_i)),
    .null_i   (null_sel_w),
    .rpl_i    (sel_i[1:0]),
    .cpl_i    (cpl_i),
    .long64_i (long64_i),
    .flags_i  (flags_w),
    .gp_o     (gp_w),
    .ss_o     (ss_w),
    .np_o     (np_w)
  );

  seg_state_reg u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load_i),
    .commit_i (commit_w),
    .zf_en_i  (zf_en_i),
    .null_i   (null_sel_w),
    .base_i   (new_base_w),
    .limit_i  (new_limit_w),
    .attr_i   (new_attr_w),
    .gp_i     (gp_w),
    .ss_i     (ss_w),
    .np_i     (np_w),
    .derr_i   (derr_w),
    .sel_i    (sel_i),
    .base_o   (base_o),
    .limit_o  (limit_o),
    .attr_o   (attr_o),
    .zf_o     (zf_o),
    .gp_o     (gp_fault_o),
    .ss_o     (ss_fault_o),
    .np_o     (np_fault_o),
    .derr_o   (desc_err_o),
    .err_o    (err_code_o)
  );
endmodule

// File: rtl/seg_desc_loader_chk.sv
module seg_desc_loader_chk #(
  parameter int GRAN_SHIFT = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        load_i,
  input logic        zf_en_i,
  input logic [1:0]  chk_mode_i,
  input logic [15:0] sel_i,
  input logic        gran_i,
  input logic        sys_n_i,
  input logic        null_sel_w,
  input logic        commit_w,
  input logic [31:0] base_o,
  input logic [31:0] limit_o,
  input logic [10:0] attr_o,
  input logic        zf_o,
  input logic        gp_fault_o,
  input logic        ss_fault_o,
  input logic        np_fault_o,
  input logic        desc_err_o,
  input logic [15:0] err_code_o
);
  AST_NULL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && null_sel_w) |=> ($stable(base_o) && $stable(limit_o) && $stable(attr_o))); // R1

  AST_GRAN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_w && gran_i) |=> (limit_o[GRAN_SHIFT-1:0] == {GRAN_SHIFT{1'b1}})); // R3

  AST_SYS_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !null_sel_w && !sys_n_i) |=> (desc_err_o && $stable(base_o) && $stable(attr_o))); // R6

  AST_RET_NULL_GP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && null_sel_w && chk_mode_i == 2'd2) |=> gp_fault_o); // R10

  AST_ZF_ON_NULL: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && zf_en_i && null_sel_w) |=> zf_o); // R12

  AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gp_fault_o, ss_fault_o, np_fault_o})); // R13

  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> !(gp_fault_o || ss_fault_o || np_fault_o || desc_err_o)); // R13

  AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gp_fault_o | ss_fault_o | np_fault_o) |-> (err_code_o == $past(sel_i))); // R13

  AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    commit_w |=> !(gp_fault_o || ss_fault_o || np_fault_o || desc_err_o)); // R13
endmodule

bind seg_desc_loader seg_desc_loader_chk #(.GRAN_SHIFT(GRAN_SHIFT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .zf_en_i    (zf_en_i),
  .chk_mode_i (chk_mode_i),
  .sel_i      (sel_i),
  .gran_i     (desc_i[55]),
  .sys_n_i    (desc_i[44]),
  .null_sel_w (null_sel_w),
  .commit_w   (commit_w),
  .base_o     (base_o),
  .limit_o    (limit_o),
  .attr_o     (attr_o),
  .zf_o       (zf_o),
  .gp_fault_o (gp_fault_o),
  .ss_fault_o (ss_fault_o),
  .np_fault_o (np_fault_o),
  .desc_err_o (desc_err_o),
  .err_code_o (err_code_o)
);

// File: tb/sim_seg_desc_loader.sv
`timescale 1ns/1ps
module sim_seg_desc_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [63:0] desc_i = '0;
  logic [15:0] sel_i = '0;
  logic [1:0]  cpl_i = '0;
  logic        long64_i = 1'b0;
  logic [1:0]  chk_mode_i = '0;
  logic        zf_en_i = 1'b0;
  logic [31:0] base_o, limit_o;
  logic [10:0] attr_o;
  logic        zf_o, gp_fault_o, ss_fault_o, np_fault_o, desc_err_o;
  logic [15:0] err_code_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_base = '0, m_limit = '0;
  logic [10:0] m_attr = '0;
  logic        m_zf = 0, m_gp = 0, m_ss = 0, m_np = 0, m_derr = 0;
  logic [15:0] m_err = '0;

  always #10 clk = ~clk;

  seg_desc_loader u0 (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .desc_i(desc_i), .sel_i(sel_i),
    .cpl_i(cpl_i), .long64_i(long64_i), .chk_mode_i(chk_mode_i), .zf_en_i(zf_en_i),
    .base_o(base_o), .limit_o(limit_o), .attr_o(attr_o), .zf_o(zf_o),
    .gp_fault_o(gp_fault_o), .ss_fault_o(ss_fault_o), .np_fault_o(np_fault_o),
    .desc_err_o(desc_err_o), .err_code_o(err_code_o)
  );

  function automatic logic [63:0] mk(input int unsigned base, input int unsigned lim,
      input logic [3:0] typ, input logic s, input logic [1:0] dpl, input logic p,
      input logic l, input logic d, input logic g);
    logic [63:0] x = '0;
    x[15:0]  = lim[15:0];
    x[39:16] = base[23:0];
    x[43:40] = typ;
    x[44]    = s;
    x[46:45] = dpl;
    x[47]    = p;
    x[51:48] = lim[19:16];
    x[53]    = l;
    x[54]    = d;
    x[55]    = g;
    x[63:56] = base[31:24];
    return x;
  endfunction

  function automatic logic [15:0] mksel(input int idx, input logic ti, input logic [1:0] rpl);
    return {idx[12:0], ti, rpl};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "base", base_o, m_base);
    chk(tag, "limit", limit_o, m_limit);
    chk(tag, "attr", 32'(attr_o), 32'(m_attr));
    chk(tag, "zf", 32'(zf_o), 32'(m_zf));
    chk(tag, "faults", {29'd0, gp_fault_o, ss_fault_o, np_fault_o}, {29'd0, m_gp, m_ss, m_np});
    chk(tag, "desc_err", 32'(desc_err_o), 32'(m_derr));
    chk(tag, "err_code", 32'(err_code_o), 32'(m_err));
  endtask

  // behavioural reference for one load
  task automatic model(input logic [63:0] d, input logic [15:0] s, input logic [1:0] cpl,
      input logic m64, input logic [1:0] mode, input logic zfen);
    bit nul = (s >> 2) == 0;
    int rpl = s & 3;
    int dpl = (d >> 45) & 3;
    int c = cpl;
    bit sysd = !d[44], pres = d[47], code = d[43], b41 = d[41], b42 = d[42];
    bit g = 0, st = 0, n = 0, derr;
    if (mode == 2'd1) begin
      if (nul) g = !(m64 && c != 3);
      else if (sysd || code || !b41 || dpl != c || rpl != c) g = 1;
      else if (!pres) st = 1;
    end else if (mode == 2'd2) begin
      if (nul || rpl < c || sysd || !code) g = 1;
      else if (!b42 && dpl != rpl) g = 1;
      else if (b42 && dpl > rpl) g = 1;
      else if (!pres) n = 1;
    end
    derr = !nul && (sysd || !pres);
    m_gp = g; m_ss = st; m_np = n; m_derr = derr;
    m_err = (g || st || n) ? s : 16'd0;
    if (!nul && !derr && !(g || st || n)) begin
      longint lim = ((d >> 48) & 64'hF) * 65536 + (d & 64'hFFFF);
      m_base  = 32'(((d >> 56) << 24) + ((d >> 16) & 64'hFFFFFF));
      m_limit = d[55] ? 32'(lim * 4096 + 4095) : 32'(lim);
      m_attr  = '0;
      m_attr[1:0] = 2'(dpl);
      m_attr[2] = d[54];
      m_attr[9] = d[52];
      m_attr[10] = d[40];
      m_attr[3] = code;
      m_attr[4] = code ? b41 : 1'b1;
      m_attr[5] = code ? 1'b0 : b41;
      m_attr[6] = code ? 1'b0 : b42;
      m_attr[7] = code ? d[53] : 1'b0;
      m_attr[8] = code ? b42 : 1'b0;
    end
    if (zfen) m_zf = nul;
  endtask

  task automatic do_load(input string tag, input logic [63:0] d, input logic [15:0] s,
      input logic [1:0] cpl, input logic m64, input logic [1:0] mode, input logic zfen);
    @(negedge clk);
    desc_i = d; sel_i = s; cpl_i = cpl; long64_i = m64; chk_mode_i = mode; zf_en_i = zfen;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    model(d, s, cpl, m64, mode, zfen);
    compare_all(tag);
    @(negedge clk);
    m_gp = 0; m_ss = 0; m_np = 0; m_derr = 0; m_err = '0;
    compare_all({tag, " idle R13"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R13 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] dwr, dcode, dro;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R13 reset");

    dwr   = mk(32'h12345678, 32'hABCDE, 4'b0011, 1, 2'd0, 1, 0, 1, 0);
    do_load("R2 R3 R5 data G0", dwr, mksel(5, 0, 0), 2'd0, 0, 2'd0, 1);
    do_load("R3 data G1", mk(32'h89ABCDEF, 32'h00012, 4'b0110, 1, 2'd3, 1, 1, 0, 1),
            mksel(9, 1, 3), 2'd0, 0, 2'd0, 1);
    dcode = mk(32'hFF001000, 32'hFFFFF, 4'b1110, 1, 2'd1, 1, 1, 0, 1) | (64'd1 << 52);
    do_load("R4 code conf long", dcode, mksel(2, 0, 1), 2'd0, 0, 2'd0, 1);
    do_load("R1 R12 null", dwr, mksel(0, 0, 3), 2'd0, 0, 2'd0, 1);
    do_load("R12 zf hold", dwr, mksel(7, 0, 0), 2'd0, 0, 2'd0, 0);
    do_load("R12 zf clear", dwr, mksel(7, 0, 0), 2'd0, 0, 2'd0, 1);
    do_load("R6 system", mk(32'h0, 32'h67, 4'b1001, 0, 2'd0, 1, 0, 0, 0), mksel(4, 0, 0), 2'd0, 0, 2'd0, 1);
    do_load("R6 not present", mk(32'h55, 32'h1, 4'b0010, 1, 2'd0, 0, 0, 0, 0), mksel(4, 0, 0), 2'd0, 0, 2'd0, 1);
    do_load("R11 mode3 none", mk(32'h7700, 32'h10, 4'b1000, 1, 2'd2, 1, 0, 0, 0), mksel(3, 0, 0), 2'd0, 0, 2'd3, 1);

    // stack check
    do_load("R7 null 64 cpl0", dwr, mksel(0, 0, 0), 2'd0, 1, 2'd1, 1);
    do_load("R7 null legacy", dwr, mksel(0, 0, 1), 2'd1, 0, 2'd1, 1);
    do_load("R7 null 64 cpl3", dwr, mksel(0, 0, 3), 2'd3, 1, 2'd1, 1);
    do_load("R8 code seg", mk(32'h10, 32'h1, 4'b1010, 1, 2'd0, 1, 0, 0, 0), mksel(6, 0, 0), 2'd0, 0, 2'd1, 1);
    dro = mk(32'h20, 32'h2, 4'b0000, 1, 2'd0, 1, 0, 0, 0);
    do_load("R8 read only", dro, mksel(6, 0, 0), 2'd0, 0, 2'd1, 1);
    do_load("R8 dpl mismatch", mk(32'h30, 32'h3, 4'b0010, 1, 2'd2, 1, 0, 0, 0), mksel(6, 0, 0), 2'd0, 0, 2'd1, 1);
    do_load("R8 rpl mismatch", mk(32'h30, 32'h3, 4'b0010, 1, 2'd0, 1, 0, 0, 0), mksel(6, 0, 1), 2'd0, 0, 2'd1, 1);
    do_load("R9 stack np", mk(32'h40, 32'h4, 4'b0010, 1, 2'd3, 0, 0, 0, 0), mksel(8, 1, 3), 2'd3, 0, 2'd1, 1);
    do_load("R8 stack ok", mk(32'hCAFE0000, 32'hFFFF, 4'b0010, 1, 2'd3, 1, 0, 1, 0), mksel(8, 1, 3), 2'd3, 0, 2'd1, 1);

    // return check
    do_load("R10 null", dcode, mksel(0, 1, 0) & 16'h0003, 2'd0, 0, 2'd2, 1);
    do_load("R10 rpl below cpl", dcode, mksel(2, 0, 0), 2'd1, 0, 2'd2, 1);
    do_load("R10 data seg", dwr, mksel(2, 0, 2), 2'd1, 0, 2'd2, 1);
    do_load("R10 nonconf dpl", mk(32'h100, 32'h5, 4'b1010, 1, 2'd1, 1, 0, 0, 0), mksel(2, 0, 2), 2'd1, 0, 2'd2, 1);
    do_load("R10 conf dpl high", mk(32'h100, 32'h5, 4'b1110, 1, 2'd3, 1, 0, 0, 0), mksel(2, 0, 2), 2'd1, 0, 2'd2, 1);
    do_load("R10 conf ok", mk(32'h200, 32'h6, 4'b1110, 1, 2'd1, 1, 0, 1, 0), mksel(2, 0, 2), 2'd1, 0, 2'd2, 1);
    do_load("R11 ret np", mk(32'h300, 32'h7, 4'b1010, 1, 2'd2, 0, 0, 0, 0), mksel(11, 0, 2), 2'd1, 0, 2'd2, 1);
    do_load("R10 nonconf ok", mk(32'h400, 32'h8, 4'b1010, 1, 2'd2, 1, 1, 0, 1), mksel(11, 0, 2), 2'd1, 0, 2'd2, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule